// File: doc/BRIEF.md
# Four-Channel Polarity-Encoded PWM Generator

This block produces up to four pulse-width-modulated outputs from one shared period counter. Each channel takes a 16-bit duty word. The low fifteen bits of the word are the compare value. The top bit picks which side of that compare value drives the output high. The counter runs in one of two modes:

- Up only, which gives edge-aligned pulses.
- Up then back down, which gives centre-aligned pulses.

The counter turns around at a programmable top value. It advances once per prescaled tick, and that tick is the clock divided by a power of two.

Software writes new duty words into per-channel shadow registers. It can write one channel at a time, or write all four channels with a single bulk write. The shadows are copied into the live compare registers only when the counter returns to zero, so a pulse is never cut short or stretched.

When the run input is low, every channel drives its own configured idle level. A channel that is marked as having no output attached also drives its idle level all the time. That channel still accepts duty writes.

Top module: `pwm4_gen`

## Requirements
- R1: After reset the outputs are all low. The configuration register resets to top = 1000, a prescaler divide of 16 (select code 4), up-only mode and an idle level of 0 on every channel.
- R2: A duty word uses bits 14:0 as the compare value and bit 15 as the polarity flag. When bit 15 is 0, the output is high while the counter is greater than or equal to the compare value.
- R3: When bit 15 of the duty word is 1, the output is high while the counter is strictly below the compare value.
- R4: In up-only mode (cfg_updown = 0) the counter steps 0, 1, …, top and then returns to 0. A period is therefore top+1 ticks.
- R5: In up-down mode (cfg_updown = 1) the counter steps from 0 up to top and then back down towards 0. A period is therefore 2·top ticks.
- R6: The counter advances once every 2^cfg_presc clock cycles while running. Each output is registered: the output after clock edge k reflects the counter value held before edge k. Counting starts from 0 at the first edge that samples run high.
- R7: A duty write lands in a shadow register. The shadow becomes the live compare word only at the edge where the counter returns to 0, or continuously while run is low.
- R8: A bulk write loads all four shadows from bulk_data in one cycle. Channel i takes bits 16·i+15 down to 16·i. The new words all take effect at the same period boundary. A bulk write has priority over a simultaneous single write.
- R9: One clock after run is sampled low, every output equals its bit of the configured idle level.
- R10: A channel whose ch_conn bit is 0 drives its idle level even while running. Duty writes to that channel leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Generator enable |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_updown | input | 1 | 0 = up only, 1 = up-down |
| cfg_top | input | 15 | Counter top value |
| cfg_presc | input | 3 | Tick divide exponent (divide by 2^n) |
| cfg_idle | input | 4 | Per-channel idle output level |
| ch_conn | input | 4 | Per-channel output-attached flag |
| duty_wr | input | 1 | Single duty write strobe |
| duty_sel | input | 2 | Channel addressed by the single write |
| duty_data | input | 16 | Duty word for the single write |
| bulk_wr | input | 1 | Write all four duty words |
| bulk_data | input | 64 | Four duty words, channel 0 in the low bits |
| pwm_out | output | 4 | Channel outputs |

## Verification
The hardest case to reach from the ports is a duty update arriving part-way through a period. The outputs must keep the old compare word until the counter wraps, and only then switch, all channels together. The bench reaches this case by starting the counter from a known edge. It then places a bulk or single write at a chosen edge offset inside a period. An independent model of the period and the tick divide predicts exactly which period first uses the new word.

A second case is an unattached channel receiving writes while it is running. It is driven in the same way, and its pin must hold the idle level.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned VAL_W  = 15;
  localparam int unsigned DUTY_W = VAL_W + 1;

  typedef enum logic {
    CNT_UP     = 1'b0,
    CNT_UPDOWN = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic             inv;
    logic [VAL_W-1:0] cmp;
  } duty_t;

  localparam logic [VAL_W-1:0] TOP_RST = VAL_W'(1000);

  // level a channel drives for a given counter value and duty word
  function automatic logic duty_level(input logic [VAL_W-1:0] cnt, input duty_t d);
    if (d.inv) return (cnt < d.cmp);
    return (cnt >= d.cmp);
  endfunction

  // counter step: returns {down_next, cnt_next}
  function automatic logic [VAL_W:0] count_step(input logic [VAL_W-1:0] cnt,
                                                input logic [VAL_W-1:0] top,
                                                input cnt_mode_e mode,
                                                input logic down);
    logic [VAL_W-1:0] n;
    logic             nd;
    n  = cnt;
    nd = down;
    if (mode == CNT_UP) begin
      nd = 1'b0;
      n  = (cnt >= top) ? '0 : cnt + 1'b1;
    end else if (!down) begin
      if (cnt >= top) begin
        n  = (top == '0) ? '0 : top - 1'b1;
        nd = (n != '0);
      end else begin
        n  = cnt + 1'b1;
        nd = 1'b0;
      end
    end else begin
      n  = (cnt == '0) ? '0 : cnt - 1'b1;
      nd = (cnt > VAL_W'(1));
    end
    return {nd, n};
  endfunction
endpackage

// File: rtl/pwm4_presc.sv
module pwm4_presc #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] lim;

  assign lim  = ({{(DIV_W-1){1'b0}}, 1'b1} << sel) - 1'b1;
  assign tick = run && (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (!run || tick)     pcnt <= '0;
    else                       pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pwm4_count.sv
module pwm4_count
  import pwm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [VAL_W-1:0] top,
  output logic [VAL_W-1:0] cnt,
  output logic             down,
  output logic             wrap
);
  logic [VAL_W:0] step;

  assign step = count_step(cnt, top, mode, down);
  assign wrap = tick && (step[VAL_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      cnt  <= step[VAL_W-1:0];
      down <= step[VAL_W];
    end
  end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             wr,
  input  duty_t            wr_word,
  input  logic             conn,
  input  logic             idle,
  input  logic [VAL_W-1:0] cnt,
  output duty_t            act,
  output logic             out
);
  duty_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
      out    <= 1'b0;
    end else begin
      if (wr)   shadow <= wr_word;
      if (load) act    <= shadow;
      out <= (run && conn) ? duty_level(cnt, act) : idle;
    end
  end
endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
  import pwm4_pkg::*;
#(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned PSC_W = 3,
  parameter int unsigned SEL_W = $clog2(CH_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     cfg_wr,
  input  logic                     cfg_updown,
  input  logic [VAL_W-1:0]         cfg_top,
  input  logic [PSC_W-1:0]         cfg_presc,
  input  logic [CH_N-1:0]          cfg_idle,
  input  logic [CH_N-1:0]          ch_conn,
  input  logic                     duty_wr,
  input  logic [SEL_W-1:0]         duty_sel,
  input  logic [DUTY_W-1:0]        duty_data,
  input  logic                     bulk_wr,
  input  logic [CH_N*DUTY_W-1:0]   bulk_data,
  output logic [CH_N-1:0]          pwm_out
);
  localparam logic [PSC_W-1:0] PSC_RST = PSC_W'(4);

  cnt_mode_e              mode_q;
  logic [VAL_W-1:0]       top_q;
  logic [PSC_W-1:0]       presc_q;
  logic [CH_N-1:0]        idle_q;

  logic                   tick;
  logic                   wrap;
  logic                   down;
  logic                   load;
  logic [VAL_W-1:0]       cnt;
  logic [CH_N*DUTY_W-1:0] act_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= CNT_UP;
      top_q   <= TOP_RST;
      presc_q <= PSC_RST;
      idle_q  <= '0;
    end else if (cfg_wr) begin
      mode_q  <= cnt_mode_e'(cfg_updown);
      top_q   <= cfg_top;
      presc_q <= cfg_presc;
      idle_q  <= cfg_idle;
    end
  end

  pwm4_presc #(.PSC_W(PSC_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (presc_q),
    .tick (tick)
  );

  pwm4_count u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .mode (mode_q),
    .top  (top_q),
    .cnt  (cnt),
    .down (down),
    .wrap (wrap)
  );

  assign load = wrap || !run;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic  wr_hit;
    duty_t wr_word;
    duty_t act;

    assign wr_hit  = bulk_wr || (duty_wr && (duty_sel == SEL_W'(i)));
    assign wr_word = bulk_wr ? duty_t'(bulk_data[i*DUTY_W +: DUTY_W]) : duty_t'(duty_data);

    pwm4_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .load   (load),
      .wr     (wr_hit),
      .wr_word(wr_word),
      .conn   (ch_conn[i]),
      .idle   (idle_q[i]),
      .cnt    (cnt),
      .act    (act),
      .out    (pwm_out[i])
    );

    assign act_flat[i*DUTY_W +: DUTY_W] = act;
  end
endmodule

// File: rtl/pwm4_gen_chk.sv
module pwm4_gen_chk #(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned PSC_W = 3,
  parameter int unsigned VAL_W = 15,
  parameter int unsigned DUTY_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   cfg_wr,
  input logic                   tick,
  input logic                   wrap,
  input logic [PSC_W-1:0]       presc_q,
  input logic [VAL_W-1:0]       cnt,
  input logic [CH_N-1:0]        idle_q,
  input logic [CH_N*DUTY_W-1:0] act_flat,
  input logic [CH_N-1:0]        pwm_out
);
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == $past(idle_q)));

  // R7
  compare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_flat));

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (presc_q != '0) && !cfg_wr) |=> !tick);

  // R4 R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> (cnt == '0));
endmodule

bind pwm4_gen pwm4_gen_chk #(
  .CH_N  (CH_N),
  .PSC_W (PSC_W),
  .VAL_W (pwm4_pkg::VAL_W),
  .DUTY_W(pwm4_pkg::DUTY_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .cfg_wr  (cfg_wr),
  .tick    (tick),
  .wrap    (wrap),
  .presc_q (presc_q),
  .cnt     (cnt),
  .idle_q  (idle_q),
  .act_flat(act_flat),
  .pwm_out (pwm_out)
);

// File: tb/test_pwm4_gen.sv
module test_pwm4_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_updown = 1'b0;
  logic [14:0] cfg_top = '0;
  logic [2:0]  cfg_presc = '0;
  logic [3:0]  cfg_idle = '0;
  logic [3:0]  ch_conn = 4'hF;
  logic        duty_wr = 1'b0;
  logic [1:0]  duty_sel = '0;
  logic [15:0] duty_data = '0;
  logic        bulk_wr = 1'b0;
  logic [63:0] bulk_data = '0;
  logic [3:0]  pwm_out;

  pwm4_gen i_pwm4_gen (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int         q_cyc[$];
  logic [3:0] q_bits[$];
  string      q_tag[$];

  // bench-side model state
  int          m_top = 1000;
  int          m_s = 4;
  bit          m_ud = 1'b0;
  logic [3:0]  m_idle = '0;
  logic [15:0] m_old[4];
  logic [15:0] m_new[4];
  int          m_wk = -1;

  // monitor: compare expected items once their cycle is reached
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (pwm_out !== q_bits[0]) begin
        failures++;
        $display("FAIL %s: pwm_out=%b expected %b (cycle %0d)", q_tag[0], pwm_out, q_bits[0], cyc);
      end
      void'(q_cyc.pop_front());
      void'(q_bits.pop_front());
      void'(q_tag.pop_front());
    end
  end

  function automatic logic [3:0] model_bits(int k);
    int div, idx, per, pi, pos, c;
    logic [15:0] d;
    logic [3:0] r;
    div = 1 << m_s;
    idx = k / div;
    per = m_ud ? 2 * m_top : m_top + 1;
    pi  = idx / per;
    pos = idx % per;
    c   = (m_ud && pos > m_top) ? 2 * m_top - pos : pos;
    for (int ch = 0; ch < 4; ch++) begin
      d = (m_wk >= 0 && pi * per * div - 1 > m_wk) ? m_new[ch] : m_old[ch];
      if (!ch_conn[ch])  r[ch] = m_idle[ch];
      else if (d[15])    r[ch] = (c < int'(d[14:0]));
      else               r[ch] = (c >= int'(d[14:0]));
    end
    return r;
  endfunction

  task automatic push(int at, logic [3:0] bits, string tag);
    q_cyc.push_back(at);
    q_bits.push_back(bits);
    q_tag.push_back(tag);
  endtask

  task automatic set_cfg(bit ud, int top, int s, logic [3:0] idle);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_updown = ud; cfg_top = 15'(top); cfg_presc = 3'(s); cfg_idle = idle;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_ud = ud; m_top = top; m_s = s; m_idle = idle;
  endtask

  task automatic load_bulk(logic [15:0] d0, logic [15:0] d1, logic [15:0] d2, logic [15:0] d3);
    @(negedge clk);
    bulk_wr = 1'b1; bulk_data = {d3, d2, d1, d0};
    @(negedge clk);
    bulk_wr = 1'b0;
    m_old[0] = d0; m_old[1] = d1; m_old[2] = d2; m_old[3] = d3;
    for (int ch = 0; ch < 4; ch++) m_new[ch] = m_old[ch];
    m_wk = -1;
    repeat (3) @(negedge clk);
  endtask

  // driver: run n cycles; mid-run write at edge wk (bulk if use_bulk, else single)
  task automatic run_window(int n, int wk, bit use_bulk, int sel, logic [15:0] wdata,
                            logic [63:0] bdata, string tag);
    if (wk >= 0) begin
      if (use_bulk) for (int ch = 0; ch < 4; ch++) m_new[ch] = bdata[ch*16 +: 16];
      else m_new[sel] = wdata;
    end
    m_wk = wk;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      run = 1'b1;
      if (k == wk) begin
        if (use_bulk) begin bulk_wr = 1'b1; bulk_data = bdata; end
        else begin duty_wr = 1'b1; duty_sel = 2'(sel); duty_data = wdata; end
      end else begin
        bulk_wr = 1'b0; duty_wr = 1'b0;
      end
      push(cyc + 1, model_bits(k), tag);
    end
    @(negedge clk);
    run = 1'b0; bulk_wr = 1'b0; duty_wr = 1'b0;
    push(cyc + 1, m_idle, "R9 stop to idle");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired, actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin m_old[ch] = '0; m_new[ch] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: all outputs low
    push(cyc, 4'b0000, "R1 reset outputs");
    repeat (2) @(negedge clk);

    // R1 defaults (top 1000, divide 16, up) with R2/R3 polarity
    load_bulk(16'h0001, 16'h8001, 16'h0001, 16'h8001);
    run_window(40, -1, 1'b0, 0, '0, '0, "R1 R6 default config");

    // R2 R3 R4: up mode, no divide
    set_cfg(1'b0, 7, 0, 4'b0000);
    load_bulk(16'h0003, 16'h8003, 16'h0000, 16'h8008);
    run_window(24, -1, 1'b0, 0, '0, '0, "R2 R3 R4 up mode");

    // R5 R6: up-down, divide by 2
    set_cfg(1'b1, 5, 1, 4'b0000);
    load_bulk(16'h0002, 16'h8004, 16'h0005, 16'h0006);
    run_window(50, -1, 1'b0, 0, '0, '0, "R5 R6 up-down");

    // R7 R8: bulk update mid-period takes effect at next wrap
    set_cfg(1'b0, 9, 0, 4'b0000);
    load_bulk(16'h0002, 16'h0005, 16'h8003, 16'h8007);
    run_window(30, 4, 1'b1, 0, '0, {16'h0000, 16'h8009, 16'h0001, 16'h0008}, "R7 R8 bulk update");

    // R7: single write to channel 2 mid-period, up-down with divide 4
    set_cfg(1'b1, 4, 2, 4'b0000);
    load_bulk(16'h0001, 16'h0002, 16'h0003, 16'h8002);
    run_window(80, 13, 1'b0, 2, 16'h8001, '0, "R7 single write");

    // R9: idle levels while disabled
    set_cfg(1'b0, 6, 0, 4'b0110);
    repeat (2) @(negedge clk);
    push(cyc, 4'b0110, "R9 idle while disabled");
    repeat (2) @(negedge clk);

    // R10: channel 2 unattached, written while running
    ch_conn = 4'b1011;
    load_bulk(16'h0002, 16'h8003, 16'h0001, 16'h0004);
    run_window(21, 5, 1'b0, 2, 16'h8000, '0, "R10 unattached channel");
    ch_conn = 4'hF;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule